// File: doc/BRIEF.md
# Bus-Master DMA Channel Status Register

This block is the 32-bit control and status word for one channel of a two-channel bus-master DMA storage controller. Software reaches it through a plain register port. A write carries a strobe, four byte enables and a data word. The read value is always present on `rd_data`. The word combines several kinds of field:

- local DMA status: completion interrupt, bus error and transfer-active;
- live copies of the sibling channel's status;
- a watchdog summary flag formed from both channels;
- a few control bits;
- a six-bit software scratch area, split into three pairs that respond to different reset events.

The completion-interrupt bit has two behaviours. While the start bit (bit 0) is set, it is a sticky flag that software clears by writing a one. Once the start bit is clear, it tracks the drive interrupt line, one clock behind. The bus-error bit is always sticky and is cleared by writing a one. The active bit is set when software raises the start bit. Hardware drops it when the engine reports the end of the transfer, or when the start bit goes low.

The scratch pairs differ only in what clears them:
- bits [13:12] are never cleared;
- bits [11:10] are cleared by the bus reset;
- bits [9:8] are cleared only by a wake pulse that signals the return from the deepest power state to the fully-on state.

Top module: `dma_chan_status_reg`

## Requirements
- R1: Writing a one to bit 17 (bus error) clears it, and so does writing a one to bit 18 (completion interrupt) while bit 0 is set. Writing zero to either bit leaves it unchanged.
- R2: When a set event (a `bus_err` pulse, or a qualifying interrupt while running) arrives in the same cycle as a write-one-to-clear of that bit, the bit ends up set.
- R3: While bit 0 is set, bit 18 becomes 1 at the edge where `drv_irq` is high and either `to_mem` is low or `mem_flushed` is high. It then stays at 1 until it is cleared.
- R4: While bit 0 is clear, bit 18 shows the value that `drv_irq` had at the previous clock edge.
- R5: Bit 16 is read-only. It goes to 1 at the edge where a write changes bit 0 from 0 to 1. It goes to 0 at the edge after an `xfer_done` pulse, and whenever bit 0 is 0.
- R6: The following bits are read-only live copies:
  - bit 20 is `own_wdog`;
  - bit 19 is `own_fifo_empty`;
  - bit 28 is `peer_wdog`;
  - bit 27 is `peer_fifo_empty`;
  - bit 15 is `own_wdog` OR `peer_wdog`.
- R7: The following bits are read-only copies of the sibling channel:
  - bits [31:29] equal `peer_cap[2:0]` (the sibling's bits [23:21]);
  - bits [26:24] equal `peer_stat[2:0]` (the sibling's bits [18:16]);
  - bit 14 equals `peer_stat[2]`.
- R8: Bit 23 and bits [7:4] always read as zero, whatever is written to them.
- R9: Bits [3:0] and [22:21] are plain read/write storage and reset to zero. Bits [22:21] affect nothing else.
- R10: A bus reset (`rst_n` low) clears scratch bits [11:10] and leaves [13:12] and [9:8] unchanged. A `pwr_wake` pulse clears [9:8], takes priority over a write in the same cycle, and leaves the other scratch bits unchanged.
- R11: A write takes effect at the clock edge where `wr_en` is sampled high. Only byte lanes whose `wr_be` bit is set are changed: lane 0 covers bits [7:0], lane 1 bits [15:8], lane 2 bits [23:16] and lane 3 bits [31:24].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Bus reset, asynchronous, active low |
| pwr_wake | input | 1 | Pulse marking the return from the deepest power state to the fully-on state |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte enables for the write |
| wr_data | input | 32 | Write data |
| drv_irq | input | 1 | Drive interrupt line |
| to_mem | input | 1 | High when the current transfer moves data from the device to memory |
| mem_flushed | input | 1 | High when all data of the transfer has reached memory |
| xfer_done | input | 1 | Pulse: all data transfers have completed |
| bus_err | input | 1 | Pulse: a bus error occurred while this channel was bus master |
| own_wdog | input | 1 | Watchdog-expired flag of this channel |
| own_fifo_empty | input | 1 | FIFO-empty flag of this channel |
| peer_wdog | input | 1 | Watchdog-expired flag of the sibling channel |
| peer_fifo_empty | input | 1 | FIFO-empty flag of the sibling channel |
| peer_cap | input | 3 | Sibling channel's bits [23:21] |
| peer_stat | input | 3 | Sibling channel's bits [18:16] |
| rd_data | output | 32 | Current register value |

## Verification
The bench drives each of the following corner cases, and each would expose a specific bug:

- **Set and clear in the same cycle.** A bus-error pulse, or a qualifying interrupt, arrives with a write-one-to-clear of the same bit. A design that let the clear win would lose the event, and the bit would read zero.
- **Unflushed device-to-memory transfer.** The interrupt rises before the data has reached memory. A design that ignored the flush condition would set bit 18 too early.
- **Stopping a DMA.** The start bit is cleared while bit 18 is set. A design that kept the sticky behaviour would not fall back to tracking the drive line.
- **Bus reset with scratch data present.** A design that wired the scratch pairs to the wrong reset would lose the never-cleared or power-state pairs, or would keep the bus-reset pair.
- **Wake pulse with a simultaneous write.** A design that let the write win would keep data in bits [9:8].
- **Partial byte enables.** A design that ignored `wr_be` would show writes in lanes that were not enabled.

// File: rtl/dma_chan_status_reg.sv
module dma_chan_status_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwr_wake,
  input  logic        wr_en,
  input  logic [3:0]  wr_be,
  input  logic [31:0] wr_data,
  input  logic        drv_irq,
  input  logic        to_mem,
  input  logic        mem_flushed,
  input  logic        xfer_done,
  input  logic        bus_err,
  input  logic        own_wdog,
  input  logic        own_fifo_empty,
  input  logic        peer_wdog,
  input  logic        peer_fifo_empty,
  input  logic [2:0]  peer_cap,
  input  logic [2:0]  peer_stat,
  output logic [31:0] rd_data
);

  logic [3:0] ctl;
  logic [1:0] cap;
  logic       irq_q, err_q, act_q;
  logic [1:0] scr_keep, scr_bus, scr_pwr;

  logic wr0, wr1, wr2;
  assign wr0 = wr_en & wr_be[0];
  assign wr1 = wr_en & wr_be[1];
  assign wr2 = wr_en & wr_be[2];

  logic start_nx, irq_hit;
  assign start_nx = wr0 ? wr_data[0] : ctl[0];
  assign irq_hit  = drv_irq & (~to_mem | mem_flushed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl     <= '0;
      cap     <= '0;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
      act_q   <= 1'b0;
      scr_bus <= '0;
    end else begin
      if (wr0) ctl <= wr_data[3:0];
      if (wr2) cap <= wr_data[22:21];
      if (wr1) scr_bus <= wr_data[11:10];

      if (!ctl[0])
        irq_q <= drv_irq;
      else if (irq_hit)
        irq_q <= 1'b1;
      else if (wr2 && wr_data[18])
        irq_q <= 1'b0;

      if (bus_err)
        err_q <= 1'b1;
      else if (wr2 && wr_data[17])
        err_q <= 1'b0;

      act_q <= start_nx & ~xfer_done & (act_q | ~ctl[0]);
    end
  end

  always_ff @(posedge clk) begin
    if (wr1) scr_keep <= wr_data[13:12];
  end

  always_ff @(posedge clk) begin
    if (pwr_wake)
      scr_pwr <= '0;
    else if (wr1)
      scr_pwr <= wr_data[9:8];
  end

  assign rd_data = {
    peer_cap,
    peer_wdog,
    peer_fifo_empty,
    peer_stat,
    1'b0,
    cap,
    own_wdog,
    own_fifo_empty,
    irq_q,
    err_q,
    act_q,
    own_wdog | peer_wdog,
    peer_stat[2],
    scr_keep,
    scr_bus,
    scr_pwr,
    4'b0000,
    ctl
  };

  // R1
  err_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[2] && wr_data[17] && !bus_err) |=> !rd_data[17]);

  // R2
  err_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> rd_data[17]);

  // R3
  irq_hold_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[0] && to_mem && !mem_flushed && !rd_data[18]) |=> !rd_data[18]);

  // R3
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[0] && rd_data[18] && !(wr_en && wr_be[2] && wr_data[18])) |=> rd_data[18]);

  // R4
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[0] |=> (rd_data[18] == $past(drv_irq)));

  // R5
  act_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[0] |-> !rd_data[16]);

  // R5
  act_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !rd_data[16]);

endmodule

// File: tb/dma_chan_status_reg_tb.sv
`timescale 1ns/1ps
module dma_chan_status_reg_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_wake = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic        drv_irq = 1'b0, to_mem = 1'b0, mem_flushed = 1'b0;
  logic        xfer_done = 1'b0, bus_err = 1'b0;
  logic        own_wdog = 1'b0, own_fifo_empty = 1'b0;
  logic        peer_wdog = 1'b0, peer_fifo_empty = 1'b0;
  logic [2:0]  peer_cap = '0, peer_stat = '0;
  logic [31:0] rd_data;

  always #2.5 clk = ~clk;

  dma_chan_status_reg u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_wake(pwr_wake), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .drv_irq(drv_irq), .to_mem(to_mem), .mem_flushed(mem_flushed),
    .xfer_done(xfer_done), .bus_err(bus_err), .own_wdog(own_wdog),
    .own_fifo_empty(own_fifo_empty), .peer_wdog(peer_wdog),
    .peer_fifo_empty(peer_fifo_empty), .peer_cap(peer_cap), .peer_stat(peer_stat),
    .rd_data(rd_data)
  );

  int n_chk = 0;
  int n_fail = 0;

  // reference state
  int m_ctl, m_cap, m_irq, m_err, m_act;
  int m_keep, m_bus, m_pwr;
  bit keep_known = 0, pwr_known = 0;

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit w0, w1, w2;
    int snx;
    w0 = wr_en && wr_be[0];
    w1 = wr_en && wr_be[1];
    w2 = wr_en && wr_be[2];
    if (pwr_wake) begin
      m_pwr = 0; pwr_known = 1;
    end else if (w1) begin
      m_pwr = (wr_data >> 8) & 3; pwr_known = 1;
    end
    if (w1) begin
      m_keep = (wr_data >> 12) & 3; keep_known = 1;
    end
    if (!rst_n) begin
      m_ctl = 0; m_cap = 0; m_irq = 0; m_err = 0; m_act = 0; m_bus = 0;
      return;
    end
    snx = w0 ? (wr_data & 1) : (m_ctl & 1);
    if ((m_ctl & 1) == 0)
      m_irq = drv_irq;
    else if (drv_irq && (!to_mem || mem_flushed))
      m_irq = 1;
    else if (w2 && wr_data[18])
      m_irq = 0;
    if (bus_err) m_err = 1;
    else if (w2 && wr_data[17]) m_err = 0;
    if (snx == 0 || xfer_done) m_act = 0;
    else if ((m_ctl & 1) == 0) m_act = 1;
    if (w1) m_bus = (wr_data >> 10) & 3;
    if (w0) m_ctl = wr_data & 15;
    if (w2) m_cap = (wr_data >> 21) & 3;
  endtask

  task automatic compare();
    int smask, sexp, sgot;
    check("R6 bit20", rd_data[20], own_wdog);
    check("R6 bit19", rd_data[19], own_fifo_empty);
    check("R6 bit28", rd_data[28], peer_wdog);
    check("R6 bit27", rd_data[27], peer_fifo_empty);
    check("R6 bit15", rd_data[15], (own_wdog || peer_wdog) ? 1 : 0);
    check("R7 peer fields", {rd_data[31:29], rd_data[26:24], rd_data[14]},
          {peer_cap, peer_stat, peer_stat[2]});
    check("R8 zero bits", {rd_data[23], rd_data[7:4]}, 0);
    check("R9 R11 ctl", rd_data[3:0], m_ctl);
    check("R9 R11 cap", rd_data[22:21], m_cap);
    check((m_ctl & 1) ? "R3 R1 R2 irq" : "R4 irq", rd_data[18], m_irq);
    check("R1 R2 err", rd_data[17], m_err);
    check("R5 active", rd_data[16], m_act);
    smask = 'hC;
    sexp = m_bus << 2;
    if (keep_known) begin smask |= 'h30; sexp |= m_keep << 4; end
    if (pwr_known)  begin smask |= 'h3;  sexp |= m_pwr; end
    sgot = rd_data[13:8];
    check("R10 R11 scratch", sgot & smask, sexp);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    compare();
    wr_en = 0; wr_be = 0; wr_data = 0;
    bus_err = 0; xfer_done = 0; pwr_wake = 0;
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    wr_en = 1; wr_be = be; wr_data = d;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1;
    step(); step();           // reset state checks
    rst_n = 1;
    step();
    // R10 wake clears power pair even with a write present
    pwr_wake = 1; wr(4'b0010, 32'h0000_3F00); step();
    wr(4'b1111, 32'hFFFF_FFFF); step();
    // R8 R1 written ones in w1c and ro lanes; check zero-bits and status
    step();
    // R10 bus reset keeps [13:12] and [9:8], clears [11:10]
    wr(4'b0010, 32'h0000_3F00); step();
    rst_n = 0; step();
    rst_n = 1; step();
    // R11 partial lanes
    wr(4'b0100, 32'h0060_000F); step();
    wr(4'b0001, 32'h0000_00F5); step();
    wr(4'b0010, 32'h0000_1500); step();
    wr(4'b1000, 32'hFFFF_FFFF); step();
    wr(4'b0001, 32'h0000_0000); step();
    // R4 idle follows irq
    drv_irq = 1; step(); step();
    drv_irq = 0; step();
    // R3 running, device-to-memory, not flushed
    to_mem = 1; mem_flushed = 0;
    wr(4'b0001, 32'h1); step();  // start, R5 active
    drv_irq = 1; step(); step();
    mem_flushed = 1; step();
    drv_irq = 0; mem_flushed = 0; step(); step();
    wr(4'b0100, 32'h0004_0000); step();  // R1 clear
    wr(4'b0100, 32'h0000_0000); step();  // zero has no effect
    // R2 set wins over clear
    to_mem = 0; drv_irq = 1; wr(4'b0100, 32'h0004_0000); step();
    drv_irq = 0; step();
    // R2 bus error
    bus_err = 1; step();
    wr(4'b0100, 32'h0000_0000); step();
    bus_err = 1; wr(4'b0100, 32'h0002_0000); step();
    wr(4'b0100, 32'h0002_0000); step();
    // R5 done pulse, restart, stop
    xfer_done = 1; step(); step();
    wr(4'b0001, 32'h0); step();
    wr(4'b0001, 32'h1); step();
    wr(4'b0001, 32'h0); step(); step();
    // R6 R7 mirrors
    for (int i = 0; i < 64; i++) begin
      {own_wdog, own_fifo_empty, peer_wdog, peer_fifo_empty} = i[3:0];
      peer_cap = i[5:3]; peer_stat = i[2:0] ^ i[5:3];
      step();
    end
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      drv_irq = r[0]; to_mem = r[1]; mem_flushed = r[2];
      bus_err = (r[7:3] == 0); xfer_done = (r[12:8] == 0);
      own_wdog = r[13]; own_fifo_empty = r[14]; peer_wdog = r[15];
      peer_fifo_empty = r[16]; peer_cap = r[19:17]; peer_stat = r[22:20];
      pwr_wake = (r[29:24] == 0);
      if (r[23]) wr(4'($urandom), $urandom);
      rst_n = (r[31:25] != 0);
      step();
      rst_n = 1;
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule